// File: doc/BRIEF.md
# Address Range Trace Filter

This block screens a stream of observed data accesses before they reach the trace merger. Each access carries an address, a data value, a transfer size and a read/write flag. A set of programmable comparators tests the address. A comparator matches either one exact address or an inclusive window between a base and a limit. It can be restricted to reads, to writes, or to both.

Each comparator carries an action code. The action can keep the access, drop it, switch the trace session on, or switch it off. When several comparators hit the same access, the one with the lowest index decides. An access that no comparator claims passes only if a default-pass bit is set. Ordinary kept accesses leave the block only while the session is on. A start trigger is always kept. A stop trigger is always dropped. Either trigger changes the session state from the following cycle onward.

Software programs the comparators through a word-wide register write port. The port selects a comparator index and one of four registers: base, limit, control, or the shared global register. Kept accesses appear on a registered output one cycle after they arrive, together with the session state.

Top module: `addr_trace_filter`

## Requirements
- R1: After reset `out_valid` is 0, `trace_on` is 0, every comparator is disabled and default-pass is 0.
- R2: A comparator in single mode (control bit 1 = 0) hits only when the access address equals its base.
- R3: A comparator in range mode (control bit 1 = 1) hits when base <= address <= limit, both ends included. A comparator whose base is above its limit never hits.
- R4: Control bit 2 lets a comparator hit read accesses (`in_write`=0), and control bit 3 lets it hit write accesses (`in_write`=1). A comparator never hits an access of a direction whose bit is clear.
- R5: Action code 0 (control bits 5:4) keeps the access only while `trace_on` is 1. A kept access appears on `out_valid` one cycle after `in_valid`, with its address, data, size and direction unchanged.
- R6: Action code 1 drops the access whatever the session state.
- R7: Action code 2 keeps the triggering access even while the session is off, and `trace_on` is 1 from the next cycle.
- R8: Action code 3 drops the triggering access, and `trace_on` is 0 from the next cycle.
- R9: When several comparators hit, the action of the lowest-index comparator applies.
- R10: An access that no comparator hits is kept only when `trace_on` is 1 and default-pass is 1.
- R11: A write to the global register (register select 3) sets default-pass from data bit 0 and `trace_on` from data bit 1. If a start or stop trigger fires in the same cycle, the trigger sets `trace_on` and the written bit 1 is ignored.
- R12: A comparator with control bit 0 clear never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_cmp | input | CW | Comparator index for base/limit/control writes |
| cfg_reg | input | 2 | Register select: 0 base, 1 limit, 2 control, 3 global |
| cfg_wdata | input | ADDR_W | Write data |
| in_valid | input | 1 | Observed access present |
| in_addr | input | ADDR_W | Access address |
| in_data | input | DATA_W | Access data value |
| in_size | input | SIZE_W | Transfer size code |
| in_write | input | 1 | 1 = write, 0 = read |
| out_valid | output | 1 | Kept access present |
| out_addr | output | ADDR_W | Kept access address |
| out_data | output | DATA_W | Kept access data |
| out_size | output | SIZE_W | Kept access size |
| out_write | output | 1 | Kept access direction |
| trace_on | output | 1 | Trace session state |

## Verification
Exact-address accesses at the base and one step beside it separate single-mode matching from range matching. Accesses at both window ends and just outside them expose off-by-one bounds and inverted windows. Read and write accesses to the same address distinguish the direction qualifiers. Overlapping comparators are configured with opposite actions in both index orders, so a priority inversion shows as a kept or lost event. Stop and start triggers are interleaved with unclaimed accesses to show when the session state changes, which triggering event is kept, and how a trigger interacts with a simultaneous global register write.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
   typedef enum logic [1:0] {
      ACT_RECORD  = 2'd0,
      ACT_DISCARD = 2'd1,
      ACT_START   = 2'd2,
      ACT_STOP    = 2'd3
   } afilt_act_e;

   localparam int CTL_EN    = 0;
   localparam int CTL_RANGE = 1;
   localparam int CTL_RD    = 2;
   localparam int CTL_WR    = 3;
   localparam int CTL_ACT_L = 4;
   localparam int CTL_W     = 6;

   localparam logic [1:0] REG_BASE   = 2'd0;
   localparam logic [1:0] REG_LIMIT  = 2'd1;
   localparam logic [1:0] REG_CTRL   = 2'd2;
   localparam logic [1:0] REG_GLOBAL = 2'd3;
endpackage

// File: rtl/afilt_cmp.sv
module afilt_cmp
   import afilt_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_base,
   input  logic              wr_limit,
   input  logic              wr_ctrl,
   input  logic [ADDR_W-1:0] wdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   output logic              hit,
   output logic [1:0]        action
);
   logic [ADDR_W-1:0] base_q, limit_q;
   logic [CTL_W-1:0]  ctrl_q;
   logic              addr_ok, dir_ok;
   logic              unused_hi;

   assign unused_hi = ^wdata[ADDR_W-1:CTL_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         limit_q <= '0;
         ctrl_q  <= '0;
      end else begin
         if (wr_base)  base_q  <= wdata;
         if (wr_limit) limit_q <= wdata;
         if (wr_ctrl)  ctrl_q  <= wdata[CTL_W-1:0];
      end
   end

   always_comb begin
      if (ctrl_q[CTL_RANGE])
         addr_ok = (acc_addr >= base_q) && (acc_addr <= limit_q);
      else
         addr_ok = (acc_addr == base_q);
      dir_ok = acc_write ? ctrl_q[CTL_WR] : ctrl_q[CTL_RD];
   end

   assign hit    = ctrl_q[CTL_EN] && addr_ok && dir_ok;
   assign action = ctrl_q[CTL_ACT_L+1:CTL_ACT_L];

   AST_HIT_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (acc_write ? ctrl_q[CTL_WR] : ctrl_q[CTL_RD])); // R4
endmodule

// File: rtl/afilt_prio.sv
module afilt_prio #(
   parameter int NUM_CMP = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CMP-1:0]      hits,
   input  logic [NUM_CMP-1:0][1:0] acts,
   output logic                    any_hit,
   output logic [1:0]              act_sel,
   output logic [NUM_CMP-1:0]      grant
);
   always_comb begin
      grant   = '0;
      act_sel = '0;
      for (int i = NUM_CMP - 1; i >= 0; i--) begin
         if (hits[i]) begin
            grant   = '0;
            grant[i] = 1'b1;
            act_sel = acts[i];
         end
      end
   end

   assign any_hit = |hits;

   AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> ((hits & (grant - 1'b1)) == '0) && ((grant & hits) != '0)); // R9
endmodule

// File: rtl/addr_trace_filter.sv
module addr_trace_filter
   import afilt_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int SIZE_W  = 2,
   parameter int NUM_CMP = 4,
   localparam int CW     = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CW-1:0]     cfg_cmp,
   input  logic [1:0]        cfg_reg,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   input  logic [SIZE_W-1:0] in_size,
   input  logic              in_write,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data,
   output logic [SIZE_W-1:0] out_size,
   output logic              out_write,
   output logic              trace_on
);
   initial begin
      if (ADDR_W < 8)   $error("ADDR_W must be at least 8");
      if (DATA_W < 1)   $error("DATA_W must be positive");
      if (SIZE_W < 1)   $error("SIZE_W must be positive");
      if (NUM_CMP < 1)  $error("NUM_CMP must be positive");
   end

   logic [NUM_CMP-1:0]      hits, grant;
   logic [NUM_CMP-1:0][1:0] acts;
   logic                    any_hit;
   logic [1:0]              act_raw;
   afilt_act_e              act_sel;
   logic                    def_pass_q;
   logic                    keep, on_nxt;
   logic                    glob_wr;
   logic                    unused_glob;

   assign glob_wr     = cfg_wr && (cfg_reg == REG_GLOBAL);
   assign unused_glob = ^cfg_wdata[ADDR_W-1:2];

   for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      logic sel;
      assign sel = cfg_wr && (cfg_cmp == CW'(g));
      afilt_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_base   (sel && (cfg_reg == REG_BASE)),
         .wr_limit  (sel && (cfg_reg == REG_LIMIT)),
         .wr_ctrl   (sel && (cfg_reg == REG_CTRL)),
         .wdata     (cfg_wdata),
         .acc_addr  (in_addr),
         .acc_write (in_write),
         .hit       (hits[g]),
         .action    (acts[g])
      );
   end

   afilt_prio #(.NUM_CMP(NUM_CMP)) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .hits    (hits),
      .acts    (acts),
      .any_hit (any_hit),
      .act_sel (act_raw),
      .grant   (grant)
   );
   assign act_sel = afilt_act_e'(act_raw);

   always_comb begin
      keep   = 1'b0;
      on_nxt = glob_wr ? cfg_wdata[1] : trace_on;
      if (in_valid) begin
         if (any_hit) begin
            unique case (act_sel)
               ACT_RECORD:  keep = trace_on;
               ACT_DISCARD: keep = 1'b0;
               ACT_START: begin
                  keep   = 1'b1;
                  on_nxt = 1'b1;
               end
               ACT_STOP: begin
                  keep   = 1'b0;
                  on_nxt = 1'b0;
               end
            endcase
         end else begin
            keep = trace_on && def_pass_q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trace_on   <= 1'b0;
         def_pass_q <= 1'b0;
         out_valid  <= 1'b0;
         out_addr   <= '0;
         out_data   <= '0;
         out_size   <= '0;
         out_write  <= 1'b0;
      end else begin
         trace_on  <= on_nxt;
         out_valid <= keep;
         if (glob_wr) def_pass_q <= cfg_wdata[0];
         if (keep) begin
            out_addr  <= in_addr;
            out_data  <= in_data;
            out_size  <= in_size;
            out_write <= in_write;
         end
      end
   end

   AST_STOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && any_hit && act_sel == ACT_STOP) |=> (!trace_on && !out_valid)); // R8
   AST_START_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && any_hit && act_sel == ACT_START) |=> (trace_on && out_valid)); // R7
   AST_DISCARD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && any_hit && act_sel == ACT_DISCARD) |=> !out_valid); // R6
   AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(in_valid) && out_addr == $past(in_addr) && out_data == $past(in_data))); // R5
   AST_UNCLAIMED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !any_hit && !def_pass_q) |=> !out_valid); // R10
   AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (any_hit == (grant != '0))); // R9
endmodule

// File: tb/addr_trace_filter_test.sv
module addr_trace_filter_test;
   localparam int CLK_P = 10;
   localparam int AW = 32, DW = 32, SW = 2, NC = 4, CW = 2;

   logic          clk = 0, rst_n = 0;
   logic          cfg_wr = 0;
   logic [CW-1:0] cfg_cmp = 0;
   logic [1:0]    cfg_reg = 0;
   logic [AW-1:0] cfg_wdata = 0;
   logic          in_valid = 0, in_write = 0;
   logic [AW-1:0] in_addr = 0;
   logic [DW-1:0] in_data = 0;
   logic [SW-1:0] in_size = 0;
   logic          out_valid, out_write, trace_on;
   logic [AW-1:0] out_addr;
   logic [DW-1:0] out_data;
   logic [SW-1:0] out_size;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   addr_trace_filter #(.ADDR_W(AW), .DATA_W(DW), .SIZE_W(SW), .NUM_CMP(NC)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_cmp(cfg_cmp), .cfg_reg(cfg_reg),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
      .in_size(in_size), .in_write(in_write), .out_valid(out_valid), .out_addr(out_addr),
      .out_data(out_data), .out_size(out_size), .out_write(out_write), .trace_on(trace_on));

   task automatic check(string req, longint act, longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] ctl(bit en, bit rng, bit rd, bit wr, logic [1:0] act);
      return AW'({act, wr, rd, rng, en});
   endfunction

   task automatic wreg(int idx, logic [1:0] r, logic [AW-1:0] d);
      @(negedge clk);
      cfg_wr = 1; cfg_cmp = CW'(idx); cfg_reg = r; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 0;
   endtask

   task automatic setup(int idx, logic [AW-1:0] b, logic [AW-1:0] l, logic [AW-1:0] c);
      wreg(idx, 2'd0, b);
      wreg(idx, 2'd1, l);
      wreg(idx, 2'd2, c);
   endtask

   task automatic clear_all();
      for (int i = 0; i < NC; i++) wreg(i, 2'd2, '0);
   endtask

   // Drives one access; outputs are sampled one cycle later, away from the edge.
   task automatic send(logic [AW-1:0] a, bit wr, string req, bit exp_v, bit exp_on);
      logic [DW-1:0] d;
      logic [SW-1:0] s;
      d = a ^ 32'hA5A5_0000;
      s = SW'(a >> 2);
      @(negedge clk);
      in_valid = 1; in_addr = a; in_write = wr; in_data = d; in_size = s;
      @(negedge clk);
      in_valid = 0;
      check(req, out_valid, exp_v);
      check(req, trace_on, exp_on);
      if (exp_v && out_valid) begin
         check(req, out_addr, a);
         check(req, out_data, d);
         check(req, out_size, s);
         check(req, out_write, wr);
      end
   endtask

   task automatic t_reset();
      check("R1", out_valid, 0);
      check("R1", trace_on, 0);
      wreg(0, 2'd3, 32'h2);                        // trace on, default-pass 0
      send(32'h10, 1, "R1", 0, 1);                 // comparators disabled, no default pass
   endtask

   task automatic t_single();
      clear_all();
      setup(0, 32'h100, 32'h1FF, ctl(1, 0, 1, 1, 2'd0));
      send(32'h100, 1, "R2", 1, 1);
      send(32'h104, 0, "R2", 0, 1);
      send(32'h180, 0, "R2", 0, 1);
   endtask

   task automatic t_range();
      clear_all();
      setup(1, 32'h200, 32'h2FF, ctl(1, 1, 1, 1, 2'd0));
      send(32'h200, 0, "R3", 1, 1);
      send(32'h2FF, 1, "R3", 1, 1);
      send(32'h1FF, 0, "R3", 0, 1);
      send(32'h300, 0, "R3", 0, 1);
      setup(1, 32'h300, 32'h200, ctl(1, 1, 1, 1, 2'd0));
      send(32'h280, 0, "R3", 0, 1);
   endtask

   task automatic t_dir();
      clear_all();
      setup(1, 32'h200, 32'h2FF, ctl(1, 1, 0, 1, 2'd0));
      send(32'h210, 0, "R4", 0, 1);
      send(32'h210, 1, "R4", 1, 1);
      setup(1, 32'h200, 32'h2FF, ctl(1, 1, 1, 0, 2'd0));
      send(32'h210, 1, "R4", 0, 1);
      send(32'h210, 0, "R4", 1, 1);
   endtask

   task automatic t_disabled();
      clear_all();
      setup(2, 32'h240, 32'h0, ctl(0, 0, 1, 1, 2'd0));
      send(32'h240, 1, "R12", 0, 1);
   endtask

   task automatic t_discard_default();
      clear_all();
      wreg(0, 2'd3, 32'h3);                        // trace on, default-pass 1
      setup(2, 32'h400, 32'h0, ctl(1, 0, 1, 1, 2'd1));
      send(32'h400, 1, "R6", 0, 1);
      send(32'h404, 1, "R10", 1, 1);
      wreg(0, 2'd3, 32'h2);
      send(32'h404, 1, "R10", 0, 1);
      wreg(0, 2'd3, 32'h3);
   endtask

   task automatic t_prio();
      clear_all();
      setup(0, 32'h500, 32'h5FF, ctl(1, 1, 1, 1, 2'd1));
      setup(1, 32'h550, 32'h0,   ctl(1, 0, 1, 1, 2'd0));
      send(32'h550, 0, "R9", 0, 1);
      setup(0, 32'h500, 32'h5FF, ctl(1, 1, 1, 1, 2'd0));
      setup(1, 32'h550, 32'h0,   ctl(1, 0, 1, 1, 2'd1));
      send(32'h550, 0, "R9", 1, 1);
   endtask

   task automatic t_stop_start();
      clear_all();
      setup(3, 32'h600, 32'h0, ctl(1, 0, 0, 1, 2'd3));
      setup(2, 32'h700, 32'h0, ctl(1, 0, 1, 1, 2'd2));
      setup(0, 32'h880, 32'h0, ctl(1, 0, 1, 1, 2'd0));
      send(32'h600, 1, "R8", 0, 0);
      send(32'h800, 0, "R8", 0, 0);                // default pass blocked while off
      send(32'h880, 0, "R5", 0, 0);                // record action while off
      send(32'h700, 0, "R7", 1, 1);
      send(32'h800, 0, "R7", 1, 1);
   endtask

   task automatic t_global_conflict();
      clear_all();
      setup(3, 32'h600, 32'h0, ctl(1, 0, 1, 1, 2'd3));
      @(negedge clk);
      cfg_wr = 1; cfg_cmp = 0; cfg_reg = 2'd3; cfg_wdata = 32'h3;
      in_valid = 1; in_addr = 32'h600; in_write = 0;
      @(negedge clk);
      cfg_wr = 0; in_valid = 0;
      check("R11", trace_on, 0);
      check("R11", out_valid, 0);
      wreg(0, 2'd3, 32'h2);
      send(32'h900, 0, "R11", 0, 1);               // default-pass now 0
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_single();
      t_range();
      t_dir();
      t_disabled();
      t_discard_default();
      t_prio();
      t_stop_start();
      t_global_conflict();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule